// File: doc/BRIEF.md
# Reset and Interrupt Vector Sequencer

This block is the bus-facing control core of an 8-bit processor with a 16-bit address space, reduced to the parts that decide where execution starts. It recognises a filtered reset and runs a seven-cycle start-up sequence that ends by loading the program counter from a fixed vector pair. It also runs the seven-cycle entry for a non-maskable and a maskable interrupt. Each entry saves the return address and the status byte on the stack page and then jumps through its own vector pair.

Between these sequences the block runs a two-cycle fetch loop. Every opcode behaves as a no-operation except `$58`, which clears the interrupt-disable flag. A system integrator uses it to bring up boards and buses: it shows the exact pin-level order of addresses, read/write strobes and opcode markers. It also freezes on a ready input and releases the bus when bus enable is low.

Top module: `vector_seq`

## Requirements
- R1: Reset is recognised only when `rst_n` is sampled low at two consecutive rising edges. A single low sample changes neither the address sequence nor the fetch rhythm.
- R2: Reset runs seven read-only cycles. It does two reads at the program counter, then three reads at `$0100`, `$01FF` and `$01FE`. The stack index starts at 0 and drops by one per cycle. It then reads `$FFFC` (low byte) and `$FFFD` (high byte). The next cycle fetches the opcode at that 16-bit address.
- R3: `sync_o` is high only in an opcode-fetch cycle. Every opcode takes two cycles, the second reading the following address. Fetch addresses rise by one per instruction. Opcode `$58` clears status bit 2 (interrupt disable), and every other opcode changes nothing.
- R4: A falling edge on `nmi_n` is latched until serviced. The entry does two reads at the program counter and three writes to page `$01`: return address high byte, then low byte, then status. The stack index decrements after each write. The entry then reads `$FFFA`/`$FFFB` and fetches from there. A level held low does not re-trigger.
- R5: A low `irq_n` seen at an instruction boundary while status bit 2 is clear starts the same entry with vector `$FFFE`/`$FFFF`. Every entry sets bit 2, so a level held low is not taken again.
- R6: While status bit 2 is set (as it is after reset), a low `irq_n` causes no stack write and no vector read.
- R7: When an NMI is pending and `irq_n` is low at the same boundary, the NMI vector is taken first. The IRQ follows once its handler clears bit 2.
- R8: While `rdy` is low, the address, R/W and SYNC outputs and all internal state hold their values.
- R9: With `be` low, `addr_oe`, `data_oe` and `rw_oe` are all low in the same cycle. With `be` high, address and R/W are driven.
- R10: `rw_o` is low only on the three stack writes of an interrupt entry, always inside page `$01`. `data_oe` is high exactly in those cycles.
- R11: A falling edge on `so_n` sets status bit 6, which appears in the next status byte pushed.
- R12: Reset leaves the status byte at `$34` (bits 5, 4 and 2 set). The stack index is `$FD` after the reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset request, sampled on the clock |
| irq_n | input | 1 | Active-low maskable interrupt level |
| nmi_n | input | 1 | Active-low non-maskable interrupt, edge-triggered |
| rdy | input | 1 | High to advance, low to freeze |
| so_n | input | 1 | Falling edge sets the overflow status bit |
| be | input | 1 | Bus enable, low releases the bus |
| addr_o | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus output enable |
| data_i | input | 8 | Data read from the bus |
| data_o | output | 8 | Data written to the bus |
| data_oe | output | 1 | Data bus output enable |
| rw_o | output | 1 | High for read, low for write |
| rw_oe | output | 1 | R/W output enable |
| sync_o | output | 1 | High in opcode-fetch cycles |

## Verification
The two functions that can meet in one cycle are the non-maskable and the maskable interrupt. Both are evaluated at the same instruction boundary. The bench clears the interrupt-disable flag, then drops `irq_n` and `nmi_n` on the same clock. It judges the result by the order of the next two vector targets ($9000 before $A000) and by the stacked return address of the second entry, which must point into the NMI handler. A second collision puts a set-overflow edge ahead of an interrupt entry; it is judged by bit 6 of the pushed status byte.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] LAST_STEP = 3'd6;
  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
  localparam logic [DATA_W-1:0] STATUS_RST = 8'h34;
  localparam logic [DATA_W-1:0] OP_CLR_MASK = 8'h58;
  localparam int BIT_IMASK = 2;
  localparam int BIT_OVF = 6;

  typedef enum logic [1:0] {ST_HOLD, ST_ENTRY, ST_FETCH, ST_EXEC} seq_state_t;
  typedef enum logic [1:0] {EK_RESET, EK_NMI, EK_IRQ} entry_kind_t;

  function automatic logic [ADDR_W-1:0] vec_low(entry_kind_t k);
    case (k)
      EK_NMI:  vec_low = 16'hFFFA;
      EK_IRQ:  vec_low = 16'hFFFE;
      default: vec_low = 16'hFFFC;
    endcase
  endfunction
endpackage

// File: rtl/vseq_low_filter.sv
module vseq_low_filter #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic hit
);
  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SAMPLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (pin_n)             cnt_d = '0;
    else if (cnt_q < CMAX) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign hit = !pin_n && (cnt_q >= CMAX);
endmodule

// File: rtl/vseq_fall_det.sv
module vseq_fall_det (
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic pin,
  output logic fall
);
  logic q;

  always_ff @(posedge clk) begin
    if (clr)     q <= 1'b1;
    else if (en) q <= pin;
  end

  assign fall = q && !pin;
endmodule

// File: rtl/vseq_core.sv
module vseq_core
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              rst_hit,
  input  logic              rdy,
  input  logic              irq_n,
  input  logic              nmi_fall,
  input  logic              so_fall,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              rw,
  output logic              sync
);
  seq_state_t        st_q, st_d;
  entry_kind_t       kind_q, kind_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] sp_q, sp_d, p_q, p_d, lo_q, lo_d, op_q, op_d;
  logic              nmi_pend_q, nmi_pend_d;
  logic              take_nmi;
  logic [ADDR_W-1:0] vec;

  assign vec = vec_low(kind_q);

  always_comb begin
    st_d = st_q; kind_d = kind_q; step_d = step_q;
    pc_d = pc_q; sp_d = sp_q; p_d = p_q; lo_d = lo_q; op_d = op_q;
    take_nmi = 1'b0;
    addr = pc_q; dout = pc_q[15:8]; rw = 1'b1; sync = 1'b0;
    case (st_q)
      ST_HOLD: begin
        if (rst_pin) begin
          st_d = ST_ENTRY; kind_d = EK_RESET; step_d = '0;
        end
      end
      ST_FETCH: begin
        sync = 1'b1;
        op_d = din;
        pc_d = pc_q + 1'b1;
        st_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (op_q == OP_CLR_MASK) p_d[BIT_IMASK] = 1'b0;
        step_d = '0;
        if (nmi_pend_q) begin
          st_d = ST_ENTRY; kind_d = EK_NMI; take_nmi = 1'b1;
        end else if (!irq_n && !p_q[BIT_IMASK]) begin
          st_d = ST_ENTRY; kind_d = EK_IRQ;
        end else begin
          st_d = ST_FETCH;
        end
      end
      default: begin
        step_d = step_q + 1'b1;
        case (step_q)
          3'd2, 3'd3, 3'd4: begin
            addr = {STACK_PAGE, sp_q};
            sp_d = sp_q - 1'b1;
            rw   = (kind_q == EK_RESET);
            if (step_q == 3'd3)      dout = pc_q[7:0];
            else if (step_q == 3'd4) dout = p_q;
            if (step_q == 3'd4) p_d[BIT_IMASK] = 1'b1;
          end
          3'd5: begin
            addr = vec;
            lo_d = din;
          end
          3'd6: begin
            addr = vec | 16'h0001;
            pc_d = {din, lo_q};
            st_d = ST_FETCH;
          end
          default: ;
        endcase
      end
    endcase
    if (so_fall) p_d[BIT_OVF] = 1'b1;
    nmi_pend_d = nmi_fall || (nmi_pend_q && !take_nmi);
  end

  always_ff @(posedge clk) begin
    if (rst_hit) begin
      st_q       <= ST_HOLD;
      sp_q       <= '0;
      p_q        <= STATUS_RST;
      nmi_pend_q <= 1'b0;
    end else if (rdy) begin
      st_q       <= st_d;
      sp_q       <= sp_d;
      p_q        <= p_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rdy) begin
      kind_q <= kind_d;
      step_q <= step_d;
      pc_q   <= pc_d;
      lo_q   <= lo_d;
      op_q   <= op_d;
    end
  end

  // R2: the vector high-byte read is followed by an opcode fetch
  assert_vec_then_fetch_R2: assert property (@(posedge clk) disable iff (!rst_pin)
    (st_q == ST_ENTRY && step_q == LAST_STEP && rdy) |=> sync);

  // R3: SYNC never lasts two advancing cycles
  assert_sync_single_R3: assert property (@(posedge clk) disable iff (!rst_pin)
    (sync && rdy) |=> !sync);

  // R7: a pending NMI wins over a low IRQ at the boundary
  assert_nmi_first_R7: assert property (@(posedge clk) disable iff (!rst_pin)
    (st_q == ST_EXEC && rdy && nmi_pend_q && !irq_n) |=> (kind_q == EK_NMI));

  // R8: bus outputs frozen while not ready
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_pin)
    (!rdy) |=> ($stable(addr) && $stable(rw) && $stable(sync)));

  // R11: overflow edge lands in the status byte
  assert_ovf_set_R11: assert property (@(posedge clk) disable iff (!rst_pin)
    (so_fall && rdy) |=> p_q[BIT_OVF]);

  // R10: writes only inside the stack page
  assert_write_page_R10: assert property (@(posedge clk) disable iff (!rst_pin)
    (!rw) |-> (addr[15:8] == STACK_PAGE));
endmodule

// File: rtl/vector_seq.sv
module vector_seq
  import vseq_pkg::*;
#(
  parameter int RST_SAMPLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              rdy,
  input  logic              so_n,
  input  logic              be,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              rw_o,
  output logic              rw_oe,
  output logic              sync_o
);
  logic rst_hit, nmi_fall, so_fall;

  vseq_low_filter #(.SAMPLES(RST_SAMPLES)) u_rst (
    .clk(clk), .pin_n(rst_n), .hit(rst_hit));

  vseq_fall_det u_nmi (
    .clk(clk), .clr(rst_hit), .en(rdy), .pin(nmi_n), .fall(nmi_fall));

  vseq_fall_det u_so (
    .clk(clk), .clr(rst_hit), .en(rdy), .pin(so_n), .fall(so_fall));

  vseq_core u_core (
    .clk(clk), .rst_pin(rst_n), .rst_hit(rst_hit), .rdy(rdy),
    .irq_n(irq_n), .nmi_fall(nmi_fall), .so_fall(so_fall), .din(data_i),
    .addr(addr_o), .dout(data_o), .rw(rw_o), .sync(sync_o));

  assign addr_oe = be;
  assign rw_oe   = be;
  assign data_oe = be && !rw_o;

  // R9: a released bus drives nothing
  assert_bus_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!be) |-> (!addr_oe && !data_oe && !rw_oe));
endmodule

// File: tb/vector_seq_tb.sv
module vector_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, rdy = 1'b1, so_n = 1'b1, be = 1'b1;
  logic [15:0] addr_o;
  logic [7:0]  data_i, data_o;
  logic addr_oe, data_oe, rw_o, rw_oe, sync_o;

  int checks = 0, errors = 0;
  logic [15:0] last_sync = '0, prev_sync = '0;
  logic [15:0] wr_a [0:7];
  logic [7:0]  wr_d [0:7];
  int wr_n = 0;
  logic [7:0] sp_m;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vector_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .rdy(rdy),
    .so_n(so_n), .be(be), .addr_o(addr_o), .addr_oe(addr_oe), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .rw_o(rw_o), .rw_oe(rw_oe), .sync_o(sync_o));

  // memory: vectors, CLI at the NMI handler start, $EA elsewhere
  always_comb begin
    case (addr_o)
      16'hFFFC: data_i = 8'h00;
      16'hFFFD: data_i = 8'h80;
      16'hFFFA: data_i = 8'h00;
      16'hFFFB: data_i = 8'h90;
      16'hFFFE: data_i = 8'h00;
      16'hFFFF: data_i = 8'hA0;
      16'h9000: data_i = 8'h58;
      default:  data_i = 8'hEA;
    endcase
  end

  // {check addr, rw, sync, addr}
  localparam logic [18:0] TBL [0:13] = '{
    {1'b0, 1'b1, 1'b0, 16'h0000}, {1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h0100}, {1'b1, 1'b1, 1'b0, 16'h01FF},
    {1'b1, 1'b1, 1'b0, 16'h01FE}, {1'b1, 1'b1, 1'b0, 16'hFFFC},
    {1'b1, 1'b1, 1'b0, 16'hFFFD}, {1'b1, 1'b1, 1'b1, 16'h8000},
    {1'b1, 1'b1, 1'b0, 16'h8001}, {1'b1, 1'b1, 1'b1, 16'h8001},
    {1'b1, 1'b1, 1'b0, 16'h8002}, {1'b1, 1'b1, 1'b1, 16'h8002},
    {1'b1, 1'b1, 1'b0, 16'h8003}, {1'b1, 1'b1, 1'b1, 16'h8003}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (be && rst_n) begin
      if (!rw_o) begin
        chk(data_oe && addr_o[15:8] == 8'h01, "R10 write cycle", {data_oe, addr_o}, {1'b1, 8'h01, 8'h00});
        if (wr_n < 8) begin wr_a[wr_n] = addr_o; wr_d[wr_n] = data_o; end
        wr_n++;
      end else if (data_oe) begin
        chk(1'b0, "R10 data_oe on read", 32'(data_oe), 32'd0);
      end
    end
    if (sync_o) begin prev_sync = last_sync; last_sync = addr_o; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) step();
    chk(rw_o && !sync_o, "R12 hold state rw/sync", {rw_o, sync_o}, 2'b10);
    rst_n = 1'b1;
  endtask

  task automatic wait_entry(input string req, input logic [15:0] exp_fetch, input logic [7:0] exp_stat);
    logic [15:0] ret;
    wr_n = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (sync_o && wr_n > 0) break;
    end
    ret = prev_sync + 16'd1;
    chk(sync_o && addr_o == exp_fetch, {req, " vector fetch"}, addr_o, exp_fetch);
    chk(wr_n == 3, {req, " push count"}, wr_n, 3);
    chk(wr_a[0] == {8'h01, sp_m} && wr_a[1] == {8'h01, sp_m - 8'd1} && wr_a[2] == {8'h01, sp_m - 8'd2},
        {req, " push addresses"}, wr_a[2], {8'h01, sp_m - 8'd2});
    chk(wr_d[0] == ret[15:8] && wr_d[1] == ret[7:0], {req, " pushed return"}, {wr_d[0], wr_d[1]}, ret);
    chk(wr_d[2] == exp_stat, {req, " pushed status"}, wr_d[2], exp_stat);
    sp_m = sp_m - 8'd3;
  endtask

  task automatic idle_no_entry(input string req, input int n);
    wr_n = 0;
    for (int i = 0; i < n; i++) step();
    chk(wr_n == 0, req, wr_n, 0);
  endtask

  initial begin
    logic [15:0] a0; logic r0, s0; int ns; bit vec_seen;
    do_reset();
    sp_m = 8'hFD;
    // R2 / R3: table of cycles after reset release
    for (int i = 0; i < 14; i++) begin
      step();
      chk(rw_o == TBL[i][17] && sync_o == TBL[i][16], "R2 R3 table rw/sync", {rw_o, sync_o}, TBL[i][17:16]);
      if (TBL[i][18]) chk(addr_o == TBL[i][15:0], "R2 R3 table addr", addr_o, TBL[i][15:0]);
    end

    // R6: IRQ while mask set after reset
    @(negedge clk); irq_n = 1'b0;
    idle_no_entry("R6 masked irq", 30);
    irq_n = 1'b1;

    // R11 then R4/R12: overflow edge then NMI, status $34|$40
    so_n = 1'b0; step(); step(); so_n = 1'b1;
    nmi_n = 1'b0;
    wait_entry("R4 R11 R12 nmi", 16'h9000, 8'h74);
    idle_no_entry("R4 nmi level no retrigger", 20);
    nmi_n = 1'b1;

    // R7 / R5: simultaneous; NMI first, then IRQ after handler CLI
    step(); step();
    irq_n = 1'b0; nmi_n = 1'b0;
    wait_entry("R7 nmi first", 16'h9000, 8'h70);
    wait_entry("R5 irq entry", 16'hA000, 8'h70);
    idle_no_entry("R5 irq level no retrigger", 30);
    irq_n = 1'b1; nmi_n = 1'b1;

    // R8: freeze
    step();
    rdy = 1'b0;
    #1 a0 = addr_o; r0 = rw_o; s0 = sync_o;
    for (int i = 0; i < 8; i++) begin
      step();
      chk(addr_o == a0 && rw_o == r0 && sync_o == s0, "R8 frozen", {addr_o, rw_o, sync_o}, {a0, r0, s0});
    end
    rdy = 1'b1;
    ns = 0;
    for (int i = 0; i < 6; i++) begin step(); if (sync_o) ns++; end
    chk(ns == 3, "R8 resumes fetch rhythm", ns, 3);

    // R9: bus release
    be = 1'b0; #1;
    chk(!addr_oe && !data_oe && !rw_oe, "R9 bus released", {addr_oe, data_oe, rw_oe}, 3'b000);
    be = 1'b1; #1;
    chk(addr_oe && rw_oe, "R9 bus driven", {addr_oe, rw_oe}, 2'b11);

    // R1: single low sample ignored
    step();
    rst_n = 1'b0; step(); rst_n = 1'b1;
    ns = 0; vec_seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (sync_o) ns++;
      if (addr_o >= 16'hFFF0 || addr_o[15:8] == 8'h01) vec_seen = 1'b1;
    end
    chk(ns == 4 && !vec_seen, "R1 short reset ignored", {ns[7:0], 7'd0, vec_seen}, {8'd4, 8'd0});

    // R1 / R2: full reset again, read-only, restart at $8000
    do_reset();
    wr_n = 0;
    for (int i = 0; i < 12; i++) begin step(); if (sync_o) break; end
    chk(sync_o && addr_o == 16'h8000, "R2 restart vector", addr_o, 16'h8000);
    chk(wr_n == 0, "R2 reset has no writes", wr_n, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule